// File: doc/BRIEF.md
# Status Register Write Unit

This unit holds the processor's live status word and one saved copy of it, both 32 bits wide. Each request writes one of them, and field enables choose which parts of the word change. The written value comes either from a general register or from an 8-bit constant rotated right by twice a 4-bit amount. A read port returns either word unchanged.

Writes to the live word follow protection rules. The condition flags, the state bit and the control bits each change only when their field enable is set. The control bits (interrupt masks and mode) also need the unit to be outside user mode. The top bit of the mode field is always forced to one, so the mode can never hold an illegal low encoding. Writes to the saved word only need the field masks. Every write to the live word raises a one-cycle pulse that tells the fetch stage to refill.

Top module: `stat_reg_unit`

## Requirements
- R1: After reset the live word is 0x000000D3 (supervisor mode 5'b10011, both interrupt masks set, flags clear), the saved word is zero and the refill pulse is low.
- R2: With `req_use_imm` high, the operand is `req_imm8` zero-extended to 32 bits and rotated right by 2*`req_rot4`. With `req_use_imm` low, the operand is `req_reg_op`.
- R3: `req_ctrl_en` enables byte 0 (mask 0x000000FF) and `req_flag_en` enables byte 3 (mask 0xFF000000). In a live write, bits 31:28 take the operand only when byte 3 is enabled.
- R4: In a live write, bit 5 (state) takes the operand only when byte 0 is enabled, whatever the current mode.
- R5: In a live write, bits 7:6 and 3:0 take the operand only when byte 0 is enabled and the current mode (bits 4:0) is not user mode 5'b10000. In user mode these bits hold.
- R6: Live bit 4 is always 1, so a new mode is {1, operand[3:0]}. Live bits 27:8 never change from zero.
- R7: A saved write (`req_saved` high) replaces the saved bits under the enabled byte mask ANDed with 0xF00000EF, in any mode, and leaves the live word unchanged.
- R8: `rd_data` shows the saved word when `rd_saved` is high and the live word otherwise, in the same cycle.
- R9: `refill` is high for exactly the cycle after a live-word request, including one with no field enabled. It stays low after saved writes and idle cycles.
- R10: `cur_mode` always equals live bits 4:0.
- R11: With `req_valid` low, neither word changes, whatever the other request inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request strobe |
| req_saved | input | 1 | 1 = write saved word, 0 = write live word |
| req_ctrl_en | input | 1 | Enable for byte 0 (control/state) |
| req_flag_en | input | 1 | Enable for byte 3 (flags) |
| req_use_imm | input | 1 | Take operand from rotated immediate |
| req_reg_op | input | 32 | Register operand |
| req_imm8 | input | 8 | Immediate constant |
| req_rot4 | input | 4 | Rotate amount, in units of two bits |
| rd_saved | input | 1 | Read select: 1 = saved word |
| rd_data | output | 32 | Selected word |
| cur_sr | output | 32 | Live status word |
| saved_sr | output | 32 | Saved status word |
| cur_mode | output | 5 | Live mode field |
| refill | output | 1 | Fetch refill pulse |

## Verification
A request is captured on the rising edge that sees `req_valid`. The new register contents and the refill pulse are both visible for the whole cycle that follows that edge. The refill pulse clears one edge later. `rd_data` and `cur_mode` are combinational, so they follow the registers with no extra delay. The bench changes inputs on the falling edge, keeps a request up for one full cycle, and reads results at the next falling edge. Refill is checked again one cycle later to confirm that it has fallen.

// File: rtl/stat_reg_pkg.sv
package stat_reg_pkg;
    localparam int SR_W = 32;
    localparam logic [SR_W-1:0] FLAG_GRP   = 32'hF000_0000;
    localparam logic [SR_W-1:0] CTRL_GRP   = 32'h0000_00CF;
    localparam logic [SR_W-1:0] STATE_GRP  = 32'h0000_0020;
    localparam logic [SR_W-1:0] SAVED_GRP  = FLAG_GRP | CTRL_GRP | STATE_GRP;
    localparam logic [SR_W-1:0] MODE_TOP   = 32'h0000_0010;
    localparam logic [SR_W-1:0] RESET_LIVE = 32'h0000_00D3;
    localparam logic [4:0]      MODE_USER  = 5'b10000;

    typedef struct packed {
        logic [SR_W-1:0] live;
        logic [SR_W-1:0] saved;
        logic            refill;
    } sr_state_t;
endpackage

// File: rtl/sr_imm_rotator.sv
module sr_imm_rotator #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    output logic [DATA_W-1:0] value
);
    localparam int AMT_W = $clog2(DATA_W);

    logic [DATA_W-1:0]   ext;
    logic [AMT_W-1:0]    amt;
    logic [2*DATA_W-1:0] twice;

    assign ext   = DATA_W'(imm);
    assign amt   = AMT_W'({rot, 1'b0});
    assign twice = {ext, ext} >> amt;
    assign value = twice[DATA_W-1:0];
endmodule

// File: rtl/sr_field_mask.sv
module sr_field_mask #(
    parameter int DATA_W = 32
) (
    input  logic              ctrl_en,
    input  logic              flag_en,
    output logic [DATA_W-1:0] mask
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_ctrl
            assign mask[g*8 +: 8] = {8{ctrl_en}};
        end else if (g == LANES - 1) begin : g_flag
            assign mask[g*8 +: 8] = {8{flag_en}};
        end else begin : g_none
            assign mask[g*8 +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/stat_reg_unit.sv
module stat_reg_unit
    import stat_reg_pkg::*;
#(
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_saved,
    input  logic             req_ctrl_en,
    input  logic             req_flag_en,
    input  logic             req_use_imm,
    input  logic [SR_W-1:0]  req_reg_op,
    input  logic [IMM_W-1:0] req_imm8,
    input  logic [ROT_W-1:0] req_rot4,
    input  logic             rd_saved,
    output logic [SR_W-1:0]  rd_data,
    output logic [SR_W-1:0]  cur_sr,
    output logic [SR_W-1:0]  saved_sr,
    output logic [4:0]       cur_mode,
    output logic             refill
);
    sr_state_t       st_d, st_q;
    logic [SR_W-1:0] imm_val_d;
    logic [SR_W-1:0] operand_d;
    logic [SR_W-1:0] field_mask_d;
    logic [SR_W-1:0] saved_mask_d;
    logic            privileged_d;

    sr_imm_rotator #(.DATA_W(SR_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
        .imm   (req_imm8),
        .rot   (req_rot4),
        .value (imm_val_d)
    );

    sr_field_mask #(.DATA_W(SR_W)) u_mask (
        .ctrl_en (req_ctrl_en),
        .flag_en (req_flag_en),
        .mask    (field_mask_d)
    );

    always_comb begin
        operand_d    = req_use_imm ? imm_val_d : req_reg_op;
        saved_mask_d = field_mask_d & SAVED_GRP;
        privileged_d = (st_q.live[4:0] != MODE_USER);
        st_d         = st_q;
        st_d.refill  = 1'b0;
        if (req_valid) begin
            if (req_saved) begin
                st_d.saved = (st_q.saved & ~saved_mask_d) | (operand_d & saved_mask_d);
            end else begin
                st_d.refill = 1'b1;
                if (|(field_mask_d & FLAG_GRP)) begin
                    st_d.live = (st_d.live & ~FLAG_GRP) | (operand_d & FLAG_GRP);
                end
                if (|(field_mask_d & STATE_GRP)) begin
                    st_d.live = (st_d.live & ~STATE_GRP) | (operand_d & STATE_GRP);
                end
                if (privileged_d && |(field_mask_d & CTRL_GRP)) begin
                    st_d.live = (st_d.live & ~CTRL_GRP) | (operand_d & CTRL_GRP) | MODE_TOP;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.live   <= RESET_LIVE;
            st_q.saved  <= '0;
            st_q.refill <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_sr   = st_q.live;
    assign saved_sr = st_q.saved;
    assign cur_mode = st_q.live[4:0];
    assign refill   = st_q.refill;
    assign rd_data  = rd_saved ? st_q.saved : st_q.live;
endmodule

// File: rtl/stat_reg_checks.sv
module stat_reg_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_saved,
    input logic [31:0] cur_sr,
    input logic [31:0] saved_sr,
    input logic        refill
);
    // R6
    mode_top_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (cur_sr[4] == 1'b1 && cur_sr[27:8] == 20'h0));

    // R9
    refill_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_saved) |=> refill);

    // R9
    refill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_saved) |=> !refill);

    // R5
    user_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_saved && cur_sr[4:0] == 5'b10000)
        |=> $stable({cur_sr[7:6], cur_sr[3:0]}));

    // R7
    saved_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_saved) |=> $stable(cur_sr));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(cur_sr) && $stable(saved_sr)));
endmodule

bind stat_reg_unit stat_reg_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_saved (req_saved),
    .cur_sr    (cur_sr),
    .saved_sr  (saved_sr),
    .refill    (refill)
);

// File: tb/stat_reg_unit_tb.sv
module stat_reg_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_saved = 1'b0;
    logic        req_ctrl_en = 1'b0;
    logic        req_flag_en = 1'b0;
    logic        req_use_imm = 1'b0;
    logic [31:0] req_reg_op = '0;
    logic [7:0]  req_imm8 = '0;
    logic [3:0]  req_rot4 = '0;
    logic        rd_saved = 1'b0;
    logic [31:0] rd_data, cur_sr, saved_sr;
    logic [4:0]  cur_mode;
    logic        refill;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_live, m_saved;

    always #4 clk = ~clk;

    stat_reg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_saved(req_saved),
        .req_ctrl_en(req_ctrl_en), .req_flag_en(req_flag_en), .req_use_imm(req_use_imm),
        .req_reg_op(req_reg_op), .req_imm8(req_imm8), .req_rot4(req_rot4),
        .rd_saved(rd_saved), .rd_data(rd_data), .cur_sr(cur_sr), .saved_sr(saved_sr),
        .cur_mode(cur_mode), .refill(refill)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ror_imm(input logic [7:0] imm, input logic [3:0] rot);
        logic [63:0] d;
        d = {24'h0, imm, 24'h0, imm} >> (2 * rot);
        return d[31:0];
    endfunction

    task automatic model(input bit sv, input bit ce, input bit fe, input logic [31:0] op);
        logic [31:0] m;
        m = (ce ? 32'h0000_00FF : 32'h0) | (fe ? 32'hFF00_0000 : 32'h0);
        if (sv) begin
            m = m & 32'hF000_00EF;
            m_saved = (m_saved & ~m) | (op & m);
        end else begin
            if (fe) m_live[31:28] = op[31:28];
            if (ce) m_live[5] = op[5];
            if (ce && m_live[4:0] != 5'b10000) begin
                m_live[7:6] = op[7:6];
                m_live[3:0] = op[3:0];
                m_live[4]   = 1'b1;
            end
        end
    endtask

    task automatic send(input bit sv, input bit ce, input bit fe, input bit ui,
                        input logic [31:0] op, input logic [7:0] imm, input logic [3:0] rot);
        @(negedge clk);
        req_valid = 1'b1; req_saved = sv; req_ctrl_en = ce; req_flag_en = fe;
        req_use_imm = ui; req_reg_op = op; req_imm8 = imm; req_rot4 = rot;
        model(sv, ce, fe, ui ? ror_imm(imm, rot) : op);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_live = 32'h0000_00D3;
        m_saved = 32'h0;
        chk("R1 live", cur_sr, 32'h0000_00D3);
        chk("R1 saved", saved_sr, 32'h0);
        chk("R1 refill", {31'h0, refill}, 32'h0);
        chk("R10 mode", {27'h0, cur_mode}, 32'h13);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0]  imms [4];
        logic [31:0] ops [5];
        imms = '{8'h01, 8'h81, 8'hA5, 8'hFF};
        ops  = '{32'hFFFF_FFFF, 32'h6000_0052, 32'h9ABC_DEA7, 32'h0000_0011, 32'h3000_0005};

        do_reset();

        // R2 / R7: rotated immediate into the saved word, every rotate amount
        for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 4; k++) begin
                send(1'b1, 1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF, imms[k], 4'(r));
                chk("R2 R7 saved imm", saved_sr, m_saved);
                chk("R7 live untouched", cur_sr, m_live);
                chk("R9 no refill on saved", {31'h0, refill}, 32'h0);
            end
        end

        // R3 R4 R5 R6: live writes in privileged mode, all enable pairs
        for (int e = 0; e < 4; e++) begin
            for (int k = 0; k < 5; k++) begin
                send(1'b0, e[0], e[1], 1'b0, ops[k], 8'h0, 4'h0);
                chk("R3 R4 R5 R6 live write", cur_sr, m_live);
                chk("R9 refill high", {31'h0, refill}, 32'h1);
                chk("R10 mode field", {27'h0, cur_mode}, {27'h0, m_live[4:0]});
                rd_saved = 1'b0; #1;
                chk("R8 read live", rd_data, m_live);
                rd_saved = 1'b1; #1;
                chk("R8 read saved", rd_data, m_saved);
            end
        end
        @(negedge clk);
        chk("R9 refill single cycle", {31'h0, refill}, 32'h0);

        // R6: mode forced legal
        send(1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0005, 8'h0, 4'h0);
        chk("R6 forced mode", {27'h0, cur_mode}, 32'h15);

        // R2: live write through immediate form (0x3F ror 2 = 0xC000000F)
        send(1'b0, 1'b1, 1'b1, 1'b1, 32'h0, 8'h3F, 4'h1);
        chk("R2 live imm", cur_sr, m_live);

        // R9: live request with no field enabled still pulses refill
        send(1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 8'h0, 4'h0);
        chk("R9 empty write refill", {31'h0, refill}, 32'h1);
        chk("R9 empty write no change", cur_sr, m_live);

        // R5: enter user mode, then priv bits are locked
        send(1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_00C0, 8'h0, 4'h0);
        chk("R5 entered user", {27'h0, cur_mode}, 32'h10);
        send(1'b0, 1'b1, 1'b1, 1'b0, 32'h5000_003F, 8'h0, 4'h0);
        chk("R5 user locked", cur_sr, m_live);
        chk("R5 user mode kept", {27'h0, cur_mode}, 32'h10);
        chk("R4 state bit in user", {31'h0, cur_sr[5]}, 32'h1);
        send(1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 8'h0, 4'h0);
        chk("R4 state clear in user", cur_sr, m_live);

        // R7: saved write in user mode has no privilege check
        send(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_00FF, 8'h0, 4'h0);
        chk("R7 saved in user", saved_sr, m_saved);

        // R11: idle cycles with busy inputs
        @(negedge clk);
        req_saved = 1'b0; req_ctrl_en = 1'b1; req_flag_en = 1'b1; req_reg_op = 32'h0;
        repeat (4) @(negedge clk);
        chk("R11 idle live", cur_sr, m_live);
        chk("R11 idle saved", saved_sr, m_saved);
        chk("R9 idle no refill", {31'h0, refill}, 32'h0);

        do_reset();
        finish_run();
    end
endmodule